// File: doc/BRIEF.md
# Byte-command I2C bus master

This block is an I2C controller that a host processor steers one byte operation at a time through a small byte-wide register window. The host programs a 16-bit clock divider and then enables the core. After that it loads a byte to send and writes a command byte. A single command can produce a start (or repeated start) condition, a byte transmit, a byte receive with a chosen acknowledge level, and a stop condition. When the command is done, the block raises an interrupt flag. The host then reads the received byte or the acknowledge result and acknowledges the flag.

The bus clock is built from a divider tick. Each bit time has five equal tick phases: two with SCL low, two with SCL released, and a final low phase. SDA therefore moves only while SCL is low, except for start and stop conditions. A bus monitor follows start and stop conditions on the wires to report whether the bus is busy. If another driver holds SDA low in a bit where this block released it, the block flags lost arbitration, abandons the command and frees both lines. The lines are open drain: an output-enable high pulls the wire low.

Top module: `i2cm_master`

## Requirements
- R1: After reset the divider reads 0x012C (offset 0 gives 0x2C, offset 1 gives 0x01), control reads 0x00, status reads 0x00, `irq` is low and both output enables are low.
- R2: Register window by byte offset: 0/1 divider low/high, 2 control (bit 7 core enable, bit 6 interrupt enable), 3 write transmit byte / read received byte, 4 write command / read status, 7 a 7-bit own-address store that reads back with bit 7 zero; unused offsets read 0. Status bits: 7 no-acknowledge, 6 bus busy, 5 arbitration lost, 1 transfer in progress, 0 interrupt flag.
- R3: Writes to the divider bytes are ignored while core enable is set.
- R4: The divider tick comes every divider+1 clocks, and SCL stays released for exactly two ticks in every data bit.
- R5: The command bits are 7 start, 6 stop, 5 read, 4 write, 3 acknowledge level and 0 flag acknowledge. Start+write emits a start condition and then shifts out the transmit byte most-significant bit first (7-bit address in bits 7:1, direction in bit 0).
- R6: While a command runs, transfer-in-progress is 1. At completion it returns to 0 and the interrupt flag is set. `irq` equals flag AND interrupt enable.
- R7: A command write with bit 0 set clears the interrupt flag.
- R8: After a byte write, the no-acknowledge status holds the SDA level sampled on the ninth clock; reads and stops leave it unchanged.
- R9: A read shifts in eight bits MSB first into the received-byte register. On the ninth clock it drives SDA low when the acknowledge bit is 0 and releases SDA when it is 1.
- R10: When stop is combined with read or write, the byte comes first and the stop follows. After the stop both lines are released.
- R11: Bus busy is set by a start condition seen on the wires and cleared by a stop condition seen on the wires.
- R12: SDA output changes while SCL is released only to form start and stop conditions.
- R13: If SDA is released by the block in a bit it owns and is sampled low, the arbitration-lost bit sets. The command ends at once with both lines released and the interrupt flag set. The next command clears arbitration-lost.
- R14: Commands written while core enable is clear are ignored. Clearing enable during a command aborts it within one clock, without setting the flag, and releases the lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Level interrupt |
| scl_oe | output | 1 | Pull SCL low when high |
| scl_in | input | 1 | SCL wire level |
| sda_oe | output | 1 | Pull SDA low when high |
| sda_in | input | 1 | SDA wire level |

## Verification
The assertions take three things for granted. The host issues a flag-only acknowledge only while no command is running. The divider is nonzero long enough that no command can finish in the clock right after it is issued. `scl_in` and `sda_in` are clean wire levels with no stretching of SCL by a target. The stimulus keeps within these limits in three ways. It waits for the interrupt before every new command, it uses a divider of 4, and it models the target as a plain open-drain device that changes SDA only on SCL falling edges. A separate bench-held SDA pull-down is used only to provoke arbitration loss.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    // register offsets
    localparam logic [2:0] A_PRE_LO = 3'd0;
    localparam logic [2:0] A_PRE_HI = 3'd1;
    localparam logic [2:0] A_CTRL   = 3'd2;
    localparam logic [2:0] A_DATA   = 3'd3;
    localparam logic [2:0] A_CMDST  = 3'd4;
    localparam logic [2:0] A_OWN    = 3'd7;

    // command and control bit positions
    localparam int C_STA  = 7;
    localparam int C_STO  = 6;
    localparam int C_RD   = 5;
    localparam int C_WR   = 4;
    localparam int C_ACK  = 3;
    localparam int C_IACK = 0;
    localparam int K_EN   = 7;
    localparam int K_IEN  = 6;

    // bit timing: five tick phases per bit, nine bits per byte slot
    localparam int PHASES = 5;
    localparam int PH_W   = $clog2(PHASES);
    localparam int BITS   = 9;
    localparam int BIT_W  = $clog2(BITS + 1);
    localparam logic [PH_W-1:0] PH_SAMP = PH_W'(3);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

    typedef enum logic [1:0] {E_IDLE, E_START, E_BIT, E_STOP} eng_st_e;

    typedef struct packed {
        logic sta;
        logic sto;
        logic rd;
        logic wr;
        logic ack;
    } cmd_t;

    typedef struct packed {
        logic       nack;
        logic       busy;
        logic       al;
        logic [2:0] rsv;
        logic       tip;
        logic       iflag;
    } stat_t;

    function automatic cmd_t decode_cmd(input logic [7:0] b);
        cmd_t c;
        c.sta = b[C_STA];
        c.sto = b[C_STO];
        c.rd  = b[C_RD];
        c.wr  = b[C_WR];
        c.ack = b[C_ACK];
        return c;
    endfunction

    function automatic logic has_op(input cmd_t c);
        return c.sta | c.sto | c.rd | c.wr;
    endfunction
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PRE_W-1:0] prescale,
    output logic             tick
);
    logic [PRE_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)          cnt <= '0;
        else if (cnt == prescale) cnt <= '0;
        else                      cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == prescale);
endmodule

// File: rtl/i2cm_busmon.sv
module i2cm_busmon (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic busy
);
    logic s_scl, s_sda, p_scl, p_sda;
    logic saw_start, saw_stop;

    always_comb begin
        saw_start = p_scl && s_scl && p_sda && !s_sda;
        saw_stop  = p_scl && s_scl && !p_sda && s_sda;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_scl <= 1'b1; s_sda <= 1'b1;
            p_scl <= 1'b1; p_sda <= 1'b1;
            busy  <= 1'b0;
        end else begin
            s_scl <= scl_in; s_sda <= sda_in;
            p_scl <= s_scl;  p_sda <= s_sda;
            if (saw_start)     busy <= 1'b1;
            else if (saw_stop) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       go,
    input  cmd_t       cmd,
    input  logic [7:0] txd,
    input  logic       tick,
    input  logic       sda_in,
    output logic       run,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       done,
    output logic       lost,
    output logic       nack,
    output logic [7:0] rxd
);
    eng_st_e          st;
    logic [PH_W-1:0]  ph;
    logic [BIT_W-1:0] bitn;
    logic [7:0]       sh;
    logic             samp, owned;
    cmd_t             cmd_q;
    logic             wmode, last_bit, rel_bit, ours;

    always_comb begin
        wmode    = !cmd_q.rd;
        last_bit = (bitn == BIT_W'(BITS - 1));
        rel_bit  = last_bit ? (wmode ? 1'b1 : cmd_q.ack) : (wmode ? sh[7] : 1'b1);
        ours     = last_bit ? !wmode : wmode;
        run      = (st != E_IDLE);
        rxd      = sh;
        case (st)
            E_START: begin
                scl_oe = (ph == PH_W'(0)) ? owned : (ph == PH_LAST);
                sda_oe = (ph >= PH_SAMP);
            end
            E_BIT: begin
                scl_oe = (ph < PH_W'(2)) || (ph == PH_LAST);
                sda_oe = !rel_bit;
            end
            E_STOP: begin
                scl_oe = (ph < PH_W'(2));
                sda_oe = (ph != PH_LAST);
            end
            default: begin
                scl_oe = owned;
                sda_oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st <= E_IDLE; ph <= '0; bitn <= '0; sh <= '0;
            samp <= 1'b1; owned <= 1'b0; cmd_q <= '0;
            done <= 1'b0; lost <= 1'b0; nack <= 1'b0;
        end else begin
            done <= 1'b0;
            lost <= 1'b0;
            if (st == E_IDLE) begin
                if (go) begin
                    cmd_q <= cmd;
                    sh    <= txd;
                    ph    <= '0;
                    bitn  <= '0;
                    if (cmd.sta)             st <= E_START;
                    else if (cmd.rd | cmd.wr) st <= E_BIT;
                    else                      st <= E_STOP;
                end
            end else if (tick) begin
                ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
                if (st == E_BIT && ph == PH_SAMP) begin
                    samp <= sda_in;
                    if (ours && rel_bit && !sda_in) begin
                        st    <= E_IDLE;
                        owned <= 1'b0;
                        done  <= 1'b1;
                        lost  <= 1'b1;
                        ph    <= '0;
                    end
                end
                if (ph == PH_LAST) begin
                    case (st)
                        E_START: begin
                            owned <= 1'b1;
                            bitn  <= '0;
                            if (cmd_q.rd | cmd_q.wr) st <= E_BIT;
                            else if (cmd_q.sto)      st <= E_STOP;
                            else begin st <= E_IDLE; done <= 1'b1; end
                        end
                        E_BIT: begin
                            if (!last_bit) begin
                                sh   <= {sh[6:0], samp};
                                bitn <= bitn + 1'b1;
                            end else begin
                                if (wmode) nack <= samp;
                                if (cmd_q.sto) st <= E_STOP;
                                else begin st <= E_IDLE; done <= 1'b1; end
                            end
                        end
                        E_STOP: begin
                            owned <= 1'b0;
                            st    <= E_IDLE;
                            done  <= 1'b1;
                        end
                        default: st <= E_IDLE;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/i2cm_master.sv
module i2cm_master
    import i2cm_pkg::*;
#(
    parameter int          PRE_W   = 16,
    parameter logic [15:0] PRE_RST = 16'h012C
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       scl_oe,
    input  logic       scl_in,
    output logic       sda_oe,
    input  logic       sda_in
);
    localparam int PB = PRE_W / 2;

    logic [PRE_W-1:0] pre_q;
    logic             en_q, ien_q, tip_q, iflag_q, al_q, cur_rd;
    logic [7:0]       txd_q, rx_q;
    logic [6:0]       own_q;
    cmd_t             cmd;
    logic             wr_cmd, go;
    logic             tick, run, eng_done, eng_lost, eng_nack, busy;
    logic [7:0]       eng_rxd;
    stat_t            stat;

    always_comb begin
        cmd    = decode_cmd(reg_wdata);
        wr_cmd = reg_wr && (reg_addr == A_CMDST);
        go     = wr_cmd && en_q && !tip_q && has_op(cmd);
    end

    i2cm_tick #(.PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst(rst), .run(run), .prescale(pre_q), .tick(tick)
    );

    i2cm_engine u_eng (
        .clk(clk), .rst(rst), .en(en_q), .go(go), .cmd(cmd), .txd(txd_q),
        .tick(tick), .sda_in(sda_in), .run(run), .scl_oe(scl_oe),
        .sda_oe(sda_oe), .done(eng_done), .lost(eng_lost), .nack(eng_nack),
        .rxd(eng_rxd)
    );

    i2cm_busmon u_mon (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .busy(busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= PRE_W'(PRE_RST);
            en_q <= 1'b0; ien_q <= 1'b0;
            txd_q <= '0; rx_q <= '0; own_q <= '0;
            tip_q <= 1'b0; iflag_q <= 1'b0; al_q <= 1'b0; cur_rd <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    A_PRE_LO: if (!en_q) pre_q[PB-1:0]     <= reg_wdata;
                    A_PRE_HI: if (!en_q) pre_q[PRE_W-1:PB] <= reg_wdata;
                    A_CTRL: begin
                        en_q  <= reg_wdata[K_EN];
                        ien_q <= reg_wdata[K_IEN];
                    end
                    A_DATA:  txd_q <= reg_wdata;
                    A_OWN:   own_q <= reg_wdata[6:0];
                    default: ;
                endcase
            end
            if (!en_q)         tip_q <= 1'b0;
            else if (go)       tip_q <= 1'b1;
            else if (eng_done) tip_q <= 1'b0;

            if (eng_done)                       iflag_q <= 1'b1;
            else if (wr_cmd && reg_wdata[C_IACK]) iflag_q <= 1'b0;

            if (go)            al_q <= 1'b0;
            else if (eng_lost) al_q <= 1'b1;

            if (go) cur_rd <= cmd.rd;
            if (eng_done && !eng_lost && cur_rd) rx_q <= eng_rxd;
        end
    end

    always_comb begin
        stat = '{nack: eng_nack, busy: busy, al: al_q, rsv: 3'b000,
                 tip: tip_q, iflag: iflag_q};
        case (reg_addr)
            A_PRE_LO: reg_rdata = pre_q[PB-1:0];
            A_PRE_HI: reg_rdata = pre_q[PRE_W-1:PB];
            A_CTRL:   reg_rdata = {en_q, ien_q, 6'b0};
            A_DATA:   reg_rdata = rx_q;
            A_CMDST:  reg_rdata = stat;
            A_OWN:    reg_rdata = {1'b0, own_q};
            default:  reg_rdata = 8'h00;
        endcase
        irq = iflag_q && ien_q;
    end
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk (
    input logic        clk,
    input logic        rst,
    input logic        en,
    input logic        tip,
    input logic        iflag,
    input logic        al,
    input logic [15:0] prescale,
    input logic        reg_wr,
    input logic [2:0]  reg_addr,
    input logic [7:0]  reg_wdata,
    input logic        scl_oe,
    input logic        sda_oe
);
    // R3: divider frozen while enabled
    a_r3_divider_locked: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && en && (reg_addr == 3'd0 || reg_addr == 3'd1)) |=> $stable(prescale));

    // R6: normal completion raises the flag
    a_r6_done_flags: assert property (@(posedge clk) disable iff (rst)
        ($fell(tip) && en) |-> iflag);

    // R7: flag acknowledge with no command running clears the flag
    a_r7_iack_clears: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd4 && reg_wdata[0] && !tip) |=> !iflag);

    // R13: arbitration loss frees the lines and flags the host
    a_r13_loss_frees_bus: assert property (@(posedge clk) disable iff (rst)
        $rose(al) |-> (!scl_oe && !sda_oe && iflag));

    // R14: disabled core is idle with lines released
    a_r14_disable_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!tip && !scl_oe && !sda_oe));
endmodule

bind i2cm_master i2cm_chk u_chk (
    .clk(clk), .rst(rst), .en(en_q), .tip(tip_q), .iflag(iflag_q), .al(al_q),
    .prescale(pre_q), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2cm_master_tb.sv
module i2cm_master_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_addr = 3'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq, scl_oe, sda_oe;
    wire        scl_line, sda_line;

    int nchk = 0, nfail = 0, nsda_hi = 0;
    logic done_flag = 1'b0;

    // target model state
    localparam logic [6:0] TGT = 7'h50;
    logic        t_low = 1'b0, t_hog = 1'b0, t_mack = 1'b1;
    logic [7:0]  t_sh = 8'h00, t_last = 8'h00;
    logic [15:0] t_txw = 16'h5AC3;
    int          t_cnt = 0, t_st = 0, t_rb = 0;
    logic        p_sda = 1'b0, p_scl = 1'b0;

    assign scl_line = !scl_oe;
    assign sda_line = !(sda_oe || t_low || t_hog);

    i2cm_master u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_oe(scl_oe), .scl_in(scl_line), .sda_oe(sda_oe), .sda_in(sda_line)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] t_cur();
        return (t_rb == 0) ? t_txw[15:8] : t_txw[7:0];
    endfunction

    always @(negedge sda_line) if (scl_line === 1'b1) begin
        t_st = 1; t_cnt = 0; t_low = 1'b0;
    end
    always @(posedge sda_line) if (scl_line === 1'b1) begin
        t_st = 0; t_low = 1'b0;
    end
    always @(posedge scl_line) if (t_st != 0) begin
        t_sh = {t_sh[6:0], sda_line};
        t_cnt++;
        if (t_cnt == 8) t_last = t_sh;
        if (t_cnt == 9) t_mack = sda_line;
    end
    always @(negedge scl_line) if (t_st != 0) begin
        if (t_cnt == 8) begin
            if (t_st == 1)      t_low = (t_last[7:1] == TGT);
            else if (t_st == 2) t_low = 1'b1;
            else                t_low = 1'b0;
        end else if (t_cnt == 9) begin
            t_cnt = 0;
            t_low = 1'b0;
            if (t_st == 1) begin
                if (t_last[7:1] != TGT) t_st = 0;
                else begin t_st = t_last[0] ? 3 : 2; t_rb = 0; end
            end else if (t_st == 3) begin
                if (t_mack) t_st = 0;
                else t_rb++;
            end
            if (t_st == 3) t_low = !t_cur()[7];
        end else if (t_st == 3 && t_cnt < 8) begin
            t_low = !t_cur()[7 - t_cnt];
        end
    end

    // R12 monitor: SDA output changes with SCL released on both sides
    always @(negedge clk) begin
        if (!rst && (sda_oe != p_sda) && !p_scl && !scl_oe) nsda_hi++;
        p_sda = sda_oe;
        p_scl = scl_oe;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 20000) begin @(negedge clk); n++; end
        nchk++;
        if (!irq) begin nfail++; $display("FAIL %s: actual no irq expected irq", req); end
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(3'd0, v); chk("R1 divider lo", v, 8'h2C);
        rd(3'd1, v); chk("R1 divider hi", v, 8'h01);
        rd(3'd2, v); chk("R1 control", v, 8'h00);
        rd(3'd4, v); chk("R1 status", v, 8'h00);
        chk("R1 irq/oe", {5'b0, irq, scl_oe, sda_oe}, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(3'd7, 8'hD5); rd(3'd7, v); chk("R2 own address", v, 8'h55);
        rd(3'd5, v); chk("R2 unused offset", v, 8'h00);
        wr(3'd0, 8'h04); wr(3'd1, 8'h00);
        rd(3'd0, v); chk("R2 divider write", v, 8'h04);
        wr(3'd2, 8'hC0); rd(3'd2, v); chk("R2 control", v, 8'hC0);
        wr(3'd0, 8'h77); wr(3'd1, 8'h33);
        rd(3'd0, v); chk("R3 divider lo locked", v, 8'h04);
        rd(3'd1, v); chk("R3 divider hi locked", v, 8'h00);
    endtask

    task automatic t_write_addr();
        logic [7:0] v;
        wr(3'd3, 8'hA0); wr(3'd4, 8'h91);
        rd(3'd4, v); chk("R6 tip during command", v & 8'h02, 8'h02);
        wait_irq("R6 address done");
        rd(3'd4, v); chk("R6 R11 status after address", v, 8'h41);
        chk("R5 target saw address", t_last, 8'hA0);
        chk("R6 irq level", {7'b0, irq}, 8'h01);
    endtask

    task automatic t_write_data();
        logic [7:0] v;
        int hi = 0;
        wr(3'd3, 8'h3C); wr(3'd4, 8'h11);
        @(posedge scl_line);
        @(negedge clk);
        while (scl_line) begin hi++; @(negedge clk); end
        chk("R4 SCL high clocks", 8'(hi), 8'd10);
        wait_irq("R6 data done");
        chk("R5 target saw data", t_last, 8'h3C);
        rd(3'd4, v); chk("R8 acked write", v, 8'h41);
    endtask

    task automatic t_iack();
        logic [7:0] v;
        wr(3'd4, 8'h01);
        rd(3'd4, v); chk("R7 flag cleared", v, 8'h40);
        chk("R7 irq low", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_read();
        logic [7:0] v;
        wr(3'd3, 8'hA1); wr(3'd4, 8'h91);
        wait_irq("R5 repeated start");
        rd(3'd4, v); chk("R5 read address acked", v, 8'h41);
        wr(3'd4, 8'h21);
        wait_irq("R9 first read");
        rd(3'd3, v); chk("R9 first byte", v, 8'h5A);
        chk("R9 acknowledge driven low", {7'b0, t_mack}, 8'h00);
        wr(3'd4, 8'h69);
        wait_irq("R10 read with stop");
        rd(3'd3, v); chk("R9 last byte", v, 8'hC3);
        chk("R9 nack released", {7'b0, t_mack}, 8'h01);
        rd(3'd4, v); chk("R10 R11 status after stop", v, 8'h01);
        chk("R10 lines released", {6'b0, scl_line, sda_line}, 8'h03);
    endtask

    task automatic t_nack();
        logic [7:0] v;
        wr(3'd3, 8'hEE); wr(3'd4, 8'h91);
        wait_irq("R8 unmatched address");
        rd(3'd4, v); chk("R8 nack flagged", v, 8'hC1);
        wr(3'd4, 8'h41);
        wait_irq("R11 stop");
        rd(3'd4, v); chk("R11 busy cleared, nack kept", v, 8'h81);
    endtask

    task automatic t_arb();
        logic [7:0] v;
        t_hog = 1'b1;
        repeat (4) @(negedge clk);
        wr(3'd3, 8'hFF); wr(3'd4, 8'h91);
        wait_irq("R13 loss");
        rd(3'd4, v); chk("R13 lost and flagged", v & 8'h23, 8'h21);
        chk("R13 lines released", {6'b0, scl_oe, sda_oe}, 8'h00);
        t_hog = 1'b0;
        repeat (6) @(negedge clk);
        wr(3'd4, 8'h01);
    endtask

    task automatic t_disable();
        logic [7:0] v;
        wr(3'd2, 8'h00);
        wr(3'd3, 8'hA0); wr(3'd4, 8'h91);
        repeat (40) @(negedge clk);
        rd(3'd4, v); chk("R14 ignored while disabled", v & 8'h03, 8'h00);
        chk("R14 lines idle", {6'b0, scl_oe, sda_oe}, 8'h00);
        wr(3'd2, 8'hC0); wr(3'd4, 8'h91);
        repeat (6) @(negedge clk);
        rd(3'd4, v); chk("R14 running before abort", v & 8'h02, 8'h02);
        wr(3'd2, 8'h00);
        repeat (2) @(negedge clk);
        rd(3'd4, v); chk("R14 aborted, no flag", v & 8'h03, 8'h00);
        chk("R14 lines released", {6'b0, scl_oe, sda_oe}, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_write_addr();
        t_write_data();
        t_iack();
        t_read();
        t_nack();
        t_arb();
        chk("R12 SDA moves under high SCL only at start/stop", 8'(nsda_hi), 8'd6);
        t_disable();
        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule